// File: doc/BRIEF.md
# Terminal-Count Reload Programmable Divider

This block is a synchronous binary up counter that divides a clock by any ratio from 2 to 2^W. When its reload control is on and the count reaches the all-ones state, the next counting edge loads a preset word instead of wrapping to zero. The counter therefore steps through N states for a preset of 2^W − N. The terminal-count flag is high in the all-ones state, so it is high for one clock in every N and serves directly as the divided output. For example, with one 8-bit stage, N = 113 needs a preset of 0x8F, and the count runs 0x8F, 0x90 … 0xFE, 0xFF, 0x8F.

A parallel-load control forces the preset in at any time. A count-enable control freezes the counter. An optional toggle stage flips each time the counter advances out of terminal count, which gives a 50 %-duty output with period 2N. To get a 50 % output of an even ratio R, load the ratio R/2. A parameter chains several 8-bit stages into one wider counter. In a chain, each upper stage advances only on the carry from the stages below it, and the reload is gated by terminal count of the whole chain, never of a single stage.

Top module: `tcr_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `count` to zero and clears `half_out`, overriding every other input.
- R2: `tc_pulse` is 1 exactly when every bit of `count` is 1, whatever the state of the enables.
- R3: With `cnt_en` high, `load_en` low and `count` not all ones, each edge adds 1 to `count`. At all ones with `tc_reload_en` low, the next value is zero.
- R4: With `cnt_en` and `load_en` both low, `count` holds its value. An all-ones count then causes no reload, even with `tc_reload_en` high.
- R5: `load_en` high loads `preset` at the next edge, regardless of `cnt_en`, `tc_reload_en` or terminal count. It has priority over counting and over the terminal-count reload.
- R6: With `cnt_en` and `tc_reload_en` high and `load_en` low, an all-ones `count` loads `preset` at the next edge. A preset of 2^W − N then makes `tc_pulse` high for one cycle in every N, for N = 2 … 2^W (e.g. W = 8, N = 113: preset 0x8F).
- R7: With `HALF_EN` = 1, `half_out` inverts on each edge where `cnt_en` is high, `load_en` low and `count` all ones, and holds otherwise. At ratio N it is high N cycles and low N cycles.
- R8: With `STAGES` > 1, stage k (bits 8k+7..8k, stage 0 least significant) advances only when counting and all lower stages are all ones. A single stage at all ones triggers no reload, so the whole word divides by 2^W − preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low freezes the counter |
| load_en | input | 1 | Forces a load of `preset` at the next edge |
| tc_reload_en | input | 1 | Enables reload of `preset` on terminal count |
| preset | input | CNT_W | Preset word, 2^CNT_W minus the divide ratio |
| count | output | CNT_W | Current counter value |
| tc_pulse | output | 1 | Terminal-count flag, the divided output |
| half_out | output | 1 | 50 %-duty output toggled at each terminal-count advance |

## Verification
The bench measures the spacing between terminal-count pulses at the two extreme ratios (2 and 256) and at 3, 113 and 255. An off-by-one in the reload, such as reloading from 0xFE or counting one extra state, shows up at once as a period of N ± 1. It holds the counter at all ones with the enable low, where a design that reloads without checking the enable jumps to the preset. It also raises `load_en` in the terminal state, where a wrong priority lets the reload or the toggle win. In the two-stage chain, the bench steps the count from 0x00FE through 0x00FF. A design that gates reload on the low stage alone would jump to the preset there instead of reaching 0x0100, and it would not divide by 300.

// File: rtl/tcr_div_pkg.sv
package tcr_div_pkg;

    // Action chosen for one counter stage on the next clock edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } stage_act_e;

    // Register set of the toggle stage
    typedef struct packed {
        logic half;
    } tog_state_t;

endpackage

// File: rtl/tcr_stage.sv
module tcr_stage
    import tcr_div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] preset,
    output logic [W-1:0] cnt,
    output logic         at_tc
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_state_t;

    stage_state_t s_d, s_q;
    stage_act_e   act;

    // Priority: reset, then load, then increment, otherwise hold
    always_comb begin
        if (rst)
            act = ACT_CLEAR;
        else if (load)
            act = ACT_LOAD;
        else if (inc)
            act = ACT_INC;
        else
            act = ACT_HOLD;

        s_d = s_q;
        case (act)
            ACT_CLEAR: s_d.cnt = '0;
            ACT_LOAD:  s_d.cnt = preset;
            ACT_INC:   s_d.cnt = s_q.cnt + W'(1);
            default:   s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cnt   = s_q.cnt;
    assign at_tc = &s_q.cnt;

endmodule

// File: rtl/tcr_chain.sv
module tcr_chain #(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 1,
    localparam int CNT_W  = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             load_en,
    input  logic             tc_reload_en,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             all_tc,
    output logic             tc_advance
);

    logic [STAGES-1:0] carry;
    logic [STAGES-1:0] stage_tc;
    logic              reload_all;
    logic              load_any;

    // Reload is gated by terminal count of the whole chain only
    assign all_tc     = &stage_tc;
    assign reload_all = cnt_en & tc_reload_en & all_tc;
    assign load_any   = load_en | reload_all;
    assign tc_advance = cnt_en & ~load_en & all_tc;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign carry[g] = cnt_en;
        end else begin : g_upper
            assign carry[g] = carry[g-1] & stage_tc[g-1];
        end

        tcr_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .load   (load_any),
            .inc    (carry[g]),
            .preset (preset[g*STAGE_W +: STAGE_W]),
            .cnt    (count[g*STAGE_W +: STAGE_W]),
            .at_tc  (stage_tc[g])
        );
    end

endmodule

// File: rtl/tcr_toggle.sv
module tcr_toggle
    import tcr_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic half
);

    tog_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (rst)
            t_d.half = 1'b0;
        else if (flip)
            t_d.half = ~t_q.half;
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign half = t_q.half;

endmodule

// File: rtl/tcr_divider.sv
module tcr_divider #(
    parameter int  STAGE_W = 8,
    parameter int  STAGES  = 1,
    parameter bit  HALF_EN = 1'b1,
    localparam int CNT_W   = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             load_en,
    input  logic             tc_reload_en,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             tc_pulse,
    output logic             half_out
);

    logic tc_advance;

    tcr_chain #(
        .STAGE_W (STAGE_W),
        .STAGES  (STAGES)
    ) u_chain (
        .clk          (clk),
        .rst          (rst),
        .cnt_en       (cnt_en),
        .load_en      (load_en),
        .tc_reload_en (tc_reload_en),
        .preset       (preset),
        .count        (count),
        .all_tc       (tc_pulse),
        .tc_advance   (tc_advance)
    );

    if (HALF_EN) begin : g_half
        tcr_toggle u_toggle (
            .clk  (clk),
            .rst  (rst),
            .flip (tc_advance),
            .half (half_out)
        );
    end else begin : g_no_half
        assign half_out = 1'b0;
    end

endmodule

// File: rtl/tcr_divider_chk.sv
module tcr_divider_chk #(
    parameter int W       = 8,
    parameter bit HALF_EN = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         load_en,
    input logic         tc_reload_en,
    input logic [W-1:0] preset,
    input logic [W-1:0] count,
    input logic         tc_pulse,
    input logic         half_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == '0) && !half_out); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !load_en && tc_pulse && !tc_reload_en |=> count == '0); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !load_en && !tc_pulse |=> count == W'($past(count) + 1'b1)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en && !load_en |=> $stable(count)); // R4

    AST_FORCED_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(preset)); // R5

    AST_TC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_en && tc_reload_en && tc_pulse |=> count == $past(preset)); // R6

    if (HALF_EN) begin : g_half_chk
        AST_HALF_FLIP: assert property (@(posedge clk) disable iff (rst)
            cnt_en && !load_en && tc_pulse |=> half_out != $past(half_out)); // R7

        AST_HALF_STILL: assert property (@(posedge clk) disable iff (rst)
            !(cnt_en && !load_en && tc_pulse) |=> $stable(half_out)); // R7
    end

endmodule

bind tcr_divider tcr_divider_chk #(
    .W       (CNT_W),
    .HALF_EN (HALF_EN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_en       (cnt_en),
    .load_en      (load_en),
    .tc_reload_en (tc_reload_en),
    .preset       (preset),
    .count        (count),
    .tc_pulse     (tc_pulse),
    .half_out     (half_out)
);

// File: tb/tcr_divider_bench.sv
`timescale 1ns/1ps
module tcr_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        load_en = 1'b0;
    logic        tc_reload_en = 1'b0;
    logic [7:0]  preset = '0;
    logic [15:0] preset_w = '0;
    logic [7:0]  count;
    logic        tc_pulse, half_out;
    logic [15:0] count_w;
    logic        tc_w, half_w;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    tcr_divider u_tcr_divider (
        .clk (clk), .rst (rst), .cnt_en (cnt_en), .load_en (load_en),
        .tc_reload_en (tc_reload_en), .preset (preset),
        .count (count), .tc_pulse (tc_pulse), .half_out (half_out)
    );

    tcr_divider #(.STAGE_W(8), .STAGES(2)) u_tcr_divider_wide (
        .clk (clk), .rst (rst), .cnt_en (cnt_en), .load_en (load_en),
        .tc_reload_en (tc_reload_en), .preset (preset_w),
        .count (count_w), .tc_pulse (tc_w), .half_out (half_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic t_reset;
        rst = 1'b1; cnt_en = 1'b0; load_en = 1'b0; tc_reload_en = 1'b0;
        step; step;
        rst = 1'b0;
        chk("R1 count after reset", 32'(count), 32'h0);
        chk("R1 half after reset", 32'(half_out), 32'h0);
        chk("R2 tc low at zero", 32'(tc_pulse), 32'h0);
    endtask

    task automatic t_period(input int n);
        int   last_tc = -1;
        int   last_h  = -1;
        int   pulses  = 0;
        logic prev_h;
        t_reset();
        preset = 8'(256 - n); load_en = 1'b1; cnt_en = 1'b1; tc_reload_en = 1'b1;
        step;
        load_en = 1'b0;
        chk($sformatf("R5 load preset N=%0d", n), 32'(count), 32'(preset));
        prev_h = half_out;
        for (int k = 1; k <= 3 * n + 2; k++) begin
            step;
            if (tc_pulse) begin
                chk($sformatf("R2 tc only at all-ones N=%0d", n), 32'(count), 32'hFF);
                if (last_tc >= 0)
                    chk($sformatf("R6 tc period N=%0d", n), 32'(k - last_tc), 32'(n));
                last_tc = k;
                pulses++;
            end
            if (half_out !== prev_h) begin
                if (last_h >= 0)
                    chk($sformatf("R7 half width N=%0d", n), 32'(k - last_h), 32'(n));
                last_h = k;
                prev_h = half_out;
            end
        end
        chk($sformatf("R6 pulses seen N=%0d", n), 32'(pulses >= 3), 32'h1);
        cnt_en = 1'b0;
    endtask

    task automatic t_seq113;
        logic [7:0] exp_v;
        t_reset();
        preset = 8'h8F; load_en = 1'b1; cnt_en = 1'b1; tc_reload_en = 1'b1;
        step;
        load_en = 1'b0;
        exp_v = 8'h8F;
        for (int i = 0; i < 120; i++) begin
            step;
            exp_v = (exp_v == 8'hFF) ? 8'h8F : exp_v + 8'd1;
            chk("R6 divide-by-113 sequence", 32'(count), 32'(exp_v));
        end
        cnt_en = 1'b0;
    endtask

    task automatic t_hold;
        t_reset();
        preset = 8'hFD; load_en = 1'b1;
        step;
        load_en = 1'b0;
        repeat (3) begin
            step;
            chk("R4 hold with enable low", 32'(count), 32'hFD);
        end
        preset = 8'hFF; load_en = 1'b1;
        step;
        load_en = 1'b0; tc_reload_en = 1'b1; preset = 8'h10;
        repeat (3) begin
            step;
            chk("R4 no reload while held", 32'(count), 32'hFF);
            chk("R2 tc high while held at all-ones", 32'(tc_pulse), 32'h1);
            chk("R7 half still while held", 32'(half_out), 32'h0);
        end
        cnt_en = 1'b1;
        step;
        cnt_en = 1'b0;
        chk("R6 reload on counting edge", 32'(count), 32'h10);
        chk("R7 half flips on reload", 32'(half_out), 32'h1);
        chk("R2 tc low after reload", 32'(tc_pulse), 32'h0);
    endtask

    task automatic t_wrap;
        t_reset();
        preset = 8'hFE; load_en = 1'b1;
        step;
        load_en = 1'b0; cnt_en = 1'b1; tc_reload_en = 1'b0; preset = 8'h33;
        step;
        chk("R3 step to all-ones", 32'(count), 32'hFF);
        chk("R2 tc at all-ones", 32'(tc_pulse), 32'h1);
        step;
        chk("R3 wrap to zero without reload", 32'(count), 32'h00);
        chk("R7 half flips on wrap", 32'(half_out), 32'h1);
        step;
        chk("R3 increment after wrap", 32'(count), 32'h01);
        cnt_en = 1'b0;
    endtask

    task automatic t_load_prio;
        logic h;
        t_reset();
        preset = 8'h20; load_en = 1'b1; cnt_en = 1'b1; tc_reload_en = 1'b1;
        step;
        load_en = 1'b0;
        step;
        chk("R3 increment", 32'(count), 32'h21);
        preset = 8'h77; load_en = 1'b1;
        step;
        chk("R5 load beats increment", 32'(count), 32'h77);
        preset = 8'hFF;
        step;
        h = half_out;
        preset = 8'h55;
        step;
        chk("R5 load beats tc reload", 32'(count), 32'h55);
        chk("R7 no flip while loading", 32'(half_out), 32'(h));
        load_en = 1'b0; cnt_en = 1'b0;
        preset = 8'h0C; load_en = 1'b1;
        step;
        load_en = 1'b0;
        chk("R5 load with counting off", 32'(count), 32'h0C);
    endtask

    task automatic t_mid_reset;
        t_reset();
        preset = 8'hFF; load_en = 1'b1;
        step;
        load_en = 1'b0; cnt_en = 1'b1; tc_reload_en = 1'b1; preset = 8'h40;
        step; step;
        rst = 1'b1;
        step;
        rst = 1'b0; cnt_en = 1'b0;
        chk("R1 reset mid-run clears count", 32'(count), 32'h0);
        chk("R1 reset mid-run clears half", 32'(half_out), 32'h0);
    endtask

    task automatic t_cascade;
        int last_tc = -1;
        t_reset();
        preset_w = 16'h00FE; load_en = 1'b1; cnt_en = 1'b1; tc_reload_en = 1'b1;
        step;
        load_en = 1'b0; preset_w = 16'h1234;
        step;
        chk("R8 low stage all-ones", 32'(count_w), 32'h00FF);
        chk("R8 no chain tc on one stage", 32'(tc_w), 32'h0);
        step;
        chk("R8 carry into upper stage", 32'(count_w), 32'h0100);
        preset_w = 16'hFED4; load_en = 1'b1;
        step;
        load_en = 1'b0;
        for (int k = 1; k <= 3 * 300 + 2; k++) begin
            step;
            if (tc_w) begin
                chk("R8 chain tc at all-ones", 32'(count_w), 32'hFFFF);
                if (last_tc >= 0)
                    chk("R8 chain divide by 300", 32'(k - last_tc), 32'd300);
                last_tc = k;
            end
        end
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run incomplete, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_hold();
        t_wrap();
        t_load_prio();
        t_mid_reset();
        t_seq113();
        t_period(2);
        t_period(3);
        t_period(4);
        t_period(113);
        t_period(255);
        t_period(256);
        t_cascade();
        summary();
        $finish;
    end

endmodule